// File: doc/BRIEF.md
# Bus-Mapped Pin Controller with Per-Pin Interrupts

This block is a bank of general-purpose pins behind an APB slave port. Software drives each pin's output value and output enable and reads back the pin levels. Every pin also has its own interrupt detector, and the block ORs the enabled detectors into one interrupt line. Each configuration bit is never written directly. One address sets the bits written as one, and a partner address clears them. A read of either address of a pair returns the current mask, so read-modify-write sequences are never needed.

The pin inputs pass through a two-stage synchronizer before software or the detectors see them. Each pin's interrupt can be set for one of three triggers:

- A level, either high or low.
- One chosen edge, either rising or falling.
- Both edges.

An edge event is latched until software acknowledges it. A level condition is never latched and follows the synchronized input. For self-test, a mode bit feeds the driven output values back into the synchronizer in place of the external pins.

The APB port has no wait states, and `pready` is held high. A write takes effect on the clock edge that ends its access phase. `prdata` is valid while `psel` is high.

Top module: `apb_pin_ctrl`

## Requirements
- R1: After reset, the following hold: `pin_out` and `pin_oe` are zero, `irq` is low, the enable, trigger, polarity and any-edge masks read zero, and the mode word reads zero.
- R2: Writing word 0 (byte offset 0x00) sets each `pin_out` bit written as one. Writing word 1 (0x04) clears each `pin_out` bit written as one. Bits written as zero keep their value.
- R3: Writing ones to word 2 (0x08) sets those `pin_oe` bits. Writing ones to word 3 (0x0C) clears them. A read of either word returns the `pin_oe` mask.
- R4: A read of word 0 returns the pin inputs after two clock edges of synchronization. A level interrupt responds on the second rising edge after a pin changes, and not on the first.
- R5: Each of the following pairs works as set/clear, and a read of either word of a pair returns the mask:
  - enable: 4 / 5 (0x10 / 0x14)
  - edge trigger: 6 / 7 (0x18 / 0x1C). A mask bit of 1 means edge trigger, and 0 means level trigger.
  - polarity: 8 / 9 (0x20 / 0x24). A mask bit of 1 means active-high or rising edge.
  - any-edge: 10 / 11 (0x28 / 0x2C)
- R6: A level-triggered pin has status 1 while its synchronized input equals its polarity bit. Writing to the acknowledge word 12 (0x30) does not affect it.
- R7: An edge-triggered pin latches status 1 on its selected edge. The status appears on the third rising edge after the pin changes. It holds through later pin changes until a one is written to that bit of word 12.
- R8: When a pin's any-edge bit is set, both edges latch status and the polarity bit is ignored. Once the any-edge bit is cleared, only the polarity-selected edge latches status.
- R9: `irq` is the OR of status ANDed with enable. A read of word 1 returns the status of every pin, enabled or not.
- R10: Bit 0 of the mode word 13 (0x34) selects loopback when it is 1. In loopback, word 0 reads `pin_out` and ignores `pin_in`. When the bit is 0, word 0 reads `pin_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Clock |
| presetn | input | 1 | Asynchronous reset, active low |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write when 1 |
| paddr | input | AW (6) | Byte address; bits [AW-1:2] pick the word |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data |
| pready | output | 1 | Always 1 |
| pin_in | input | NPINS (32) | External pin levels |
| pin_out | output | NPINS (32) | Output value for each pin |
| pin_oe | output | NPINS (32) | Output enable for each pin |
| irq | output | 1 | Combined interrupt |

## Verification
The bench samples `irq` one edge before and on the edge where the status should appear. A synchronizer that is one stage too short or too long therefore shows up as an interrupt that is early or late. It writes the acknowledge word while a level condition holds and expects `irq` to stay high. A design that latches level status, or clears it on acknowledge, fails this test. It drives edges of the wrong polarity, and drives both edges with the any-edge bit set and then cleared. This catches an override that is ignored or that persists after being cleared. It also reads status from a pin whose enable is off, which exposes status that is wrongly masked by the enable. It checks that loopback replaces the pin inputs and that leaving loopback restores them.

// File: rtl/apc_pkg.sv
package apc_pkg;
  localparam int unsigned WIDX_W = 4;
  localparam logic [WIDX_W-1:0] W_OUT_SET = 4'd0;
  localparam logic [WIDX_W-1:0] W_OUT_CLR = 4'd1;
  localparam logic [WIDX_W-1:0] W_DIR_OUT = 4'd2;
  localparam logic [WIDX_W-1:0] W_DIR_IN  = 4'd3;
  localparam logic [WIDX_W-1:0] W_EN_SET  = 4'd4;
  localparam logic [WIDX_W-1:0] W_EN_CLR  = 4'd5;
  localparam logic [WIDX_W-1:0] W_EDGE    = 4'd6;
  localparam logic [WIDX_W-1:0] W_LEVEL   = 4'd7;
  localparam logic [WIDX_W-1:0] W_POL_SET = 4'd8;
  localparam logic [WIDX_W-1:0] W_POL_CLR = 4'd9;
  localparam logic [WIDX_W-1:0] W_ANY_SET = 4'd10;
  localparam logic [WIDX_W-1:0] W_ANY_CLR = 4'd11;
  localparam logic [WIDX_W-1:0] W_ACK     = 4'd12;
  localparam logic [WIDX_W-1:0] W_MODE    = 4'd13;
endpackage

// File: rtl/apc_setclr_reg.sv
module apc_setclr_reg #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         set_hit,
  input  logic         clr_hit,
  input  logic [W-1:0] data,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       q <= '0;
    else if (set_hit) q <= q | data;
    else if (clr_hit) q <= q & ~data;
  end
endmodule

// File: rtl/apc_sync.sv
module apc_sync #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/apc_pin_irq.sv
module apc_pin_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic s,
  input  logic edge_mode,
  input  logic pol,
  input  logic any,
  input  logic ack,
  output logic status
);
  logic prev_q, latch_q, rise, fall, hit;

  assign rise = s & ~prev_q;
  assign fall = ~s & prev_q;
  assign hit  = any ? (rise | fall) : (pol ? rise : fall);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= 1'b0;
      latch_q <= 1'b0;
    end else begin
      prev_q  <= s;
      latch_q <= edge_mode & ((latch_q & ~ack) | hit);
    end
  end

  assign status = edge_mode ? latch_q : (s == pol);

  // R7
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_mode && latch_q && !ack) |=> latch_q);

  // R6
  level_nolatch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !edge_mode |=> !latch_q);
endmodule

// File: rtl/apb_pin_ctrl.sv
module apb_pin_ctrl
  import apc_pkg::*;
#(
  parameter int unsigned NPINS = 32,
  parameter int unsigned AW    = 6
) (
  input  logic             pclk,
  input  logic             presetn,
  input  logic             psel,
  input  logic             penable,
  input  logic             pwrite,
  input  logic [AW-1:0]    paddr,
  input  logic [31:0]      pwdata,
  output logic [31:0]      prdata,
  output logic             pready,
  input  logic [NPINS-1:0] pin_in,
  output logic [NPINS-1:0] pin_out,
  output logic [NPINS-1:0] pin_oe,
  output logic             irq
);
  logic [WIDX_W-1:0] widx;
  logic              wr;
  logic [NPINS-1:0]  wdat, en_q, edge_q, pol_q, any_q, sync_q, status, src;
  logic              mode_q;
  logic [1:0]        unused_lsb;

  assign unused_lsb = paddr[1:0];
  assign widx   = paddr[AW-1:2];
  assign wr     = psel & penable & pwrite;
  assign wdat   = pwdata[NPINS-1:0];
  assign pready = 1'b1;

  apc_setclr_reg #(.W(NPINS)) u_out (.clk(pclk), .rst_n(presetn),
    .set_hit(wr && widx == W_OUT_SET), .clr_hit(wr && widx == W_OUT_CLR),
    .data(wdat), .q(pin_out));
  apc_setclr_reg #(.W(NPINS)) u_dir (.clk(pclk), .rst_n(presetn),
    .set_hit(wr && widx == W_DIR_OUT), .clr_hit(wr && widx == W_DIR_IN),
    .data(wdat), .q(pin_oe));
  apc_setclr_reg #(.W(NPINS)) u_en (.clk(pclk), .rst_n(presetn),
    .set_hit(wr && widx == W_EN_SET), .clr_hit(wr && widx == W_EN_CLR),
    .data(wdat), .q(en_q));
  apc_setclr_reg #(.W(NPINS)) u_edge (.clk(pclk), .rst_n(presetn),
    .set_hit(wr && widx == W_EDGE), .clr_hit(wr && widx == W_LEVEL),
    .data(wdat), .q(edge_q));
  apc_setclr_reg #(.W(NPINS)) u_pol (.clk(pclk), .rst_n(presetn),
    .set_hit(wr && widx == W_POL_SET), .clr_hit(wr && widx == W_POL_CLR),
    .data(wdat), .q(pol_q));
  apc_setclr_reg #(.W(NPINS)) u_any (.clk(pclk), .rst_n(presetn),
    .set_hit(wr && widx == W_ANY_SET), .clr_hit(wr && widx == W_ANY_CLR),
    .data(wdat), .q(any_q));

  always_ff @(posedge pclk or negedge presetn) begin
    if (!presetn)                 mode_q <= 1'b0;
    else if (wr && widx == W_MODE) mode_q <= pwdata[0];
  end

  assign src = mode_q ? pin_out : pin_in;

  apc_sync #(.W(NPINS)) u_sync (.clk(pclk), .rst_n(presetn), .d(src), .q(sync_q));

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    apc_pin_irq u_irq (
      .clk(pclk), .rst_n(presetn), .s(sync_q[i]),
      .edge_mode(edge_q[i]), .pol(pol_q[i]), .any(any_q[i]),
      .ack(wr && widx == W_ACK && wdat[i]),
      .status(status[i]));
  end

  assign irq = |(status & en_q);

  always_comb begin
    prdata = '0;
    if (psel) begin
      unique case (widx)
        W_OUT_SET:            prdata = 32'(sync_q);
        W_OUT_CLR:            prdata = 32'(status);
        W_DIR_OUT, W_DIR_IN:  prdata = 32'(pin_oe);
        W_EN_SET, W_EN_CLR:   prdata = 32'(en_q);
        W_EDGE, W_LEVEL:      prdata = 32'(edge_q);
        W_POL_SET, W_POL_CLR: prdata = 32'(pol_q);
        W_ANY_SET, W_ANY_CLR: prdata = 32'(any_q);
        W_MODE:               prdata = {31'd0, mode_q};
        default:              prdata = '0;
      endcase
    end
  end

  // R2
  out_set_chk: assert property (@(posedge pclk) disable iff (!presetn)
    (wr && widx == W_OUT_SET) |=> ((pin_out & $past(wdat)) == $past(wdat)));

  // R3
  dir_set_chk: assert property (@(posedge pclk) disable iff (!presetn)
    (wr && widx == W_DIR_OUT) |=> ((pin_oe & $past(wdat)) == $past(wdat)));

  // R9
  masked_quiet_chk: assert property (@(posedge pclk) disable iff (!presetn)
    (en_q == '0) |-> !irq);

  // R3
  dir_clr_chk: assert property (@(posedge pclk) disable iff (!presetn)
    (wr && widx == W_DIR_IN) |=> ((pin_oe & $past(wdat)) == '0));
endmodule

// File: tb/apb_pin_ctrl_test.sv
`timescale 1ns/1ps
module apb_pin_ctrl_test;
  logic        pclk = 1'b0, presetn = 1'b0;
  logic        psel = 0, penable = 0, pwrite = 0;
  logic [5:0]  paddr = '0;
  logic [31:0] pwdata = '0, prdata, pin_in = '0, pin_out, pin_oe;
  logic        pready, irq;
  int          n_run = 0, n_fail = 0;
  bit          done = 0;

  always #2.5 pclk = ~pclk;

  apb_pin_ctrl uut (.pclk, .presetn, .psel, .penable, .pwrite, .paddr, .pwdata,
    .prdata, .pready, .pin_in, .pin_out, .pin_oe, .irq);

  // {write word, write data, read word, expected readback}
  localparam logic [71:0] TBL [12] = '{
    {4'd2,  32'h0000FFFF, 4'd3,  32'h0000FFFF},
    {4'd3,  32'h000000FF, 4'd2,  32'h0000FF00},
    {4'd4,  32'hA5A5A5A5, 4'd5,  32'hA5A5A5A5},
    {4'd5,  32'h00000005, 4'd4,  32'hA5A5A5A0},
    {4'd6,  32'hFFFF0000, 4'd7,  32'hFFFF0000},
    {4'd7,  32'h0F000000, 4'd6,  32'hF0FF0000},
    {4'd8,  32'h12345678, 4'd9,  32'h12345678},
    {4'd9,  32'h00000070, 4'd8,  32'h12345608},
    {4'd10, 32'h00000003, 4'd11, 32'h00000003},
    {4'd11, 32'h00000001, 4'd10, 32'h00000002},
    {4'd13, 32'h00000001, 4'd13, 32'h00000001},
    {4'd13, 32'h00000000, 4'd13, 32'h00000000}};

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] w, logic [31:0] d);
    @(negedge pclk); psel = 1; pwrite = 1; penable = 0; paddr = {w, 2'b00}; pwdata = d;
    @(negedge pclk); penable = 1;
    @(negedge pclk); psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic rd(logic [3:0] w, output logic [31:0] d);
    @(negedge pclk); psel = 1; pwrite = 0; penable = 0; paddr = {w, 2'b00};
    @(negedge pclk); penable = 1;
    @(negedge pclk); d = prdata; psel = 0; penable = 0;
  endtask

  task automatic wait_n(int n);
    for (int i = 0; i < n; i++) @(negedge pclk);
  endtask

  task automatic do_reset();
    @(negedge pclk); presetn = 0; pin_in = '0;
    wait_n(3); presetn = 1;
  endtask

  initial begin
    #750000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    do_reset();
    // R5 R3 R10 set/clear pairs through readback
    for (int i = 0; i < 12; i++) begin
      wr(TBL[i][71:68], TBL[i][67:36]);
      rd(TBL[i][35:32], v);
      chk("R5 table readback", v, TBL[i][31:0]);
    end

    do_reset();
    // R1 reset state
    chk("R1 pin_out", pin_out, 32'h0);
    chk("R1 pin_oe", pin_oe, 32'h0);
    chk("R1 irq", {31'd0, irq}, 32'h0);
    chk("R1 pready", {31'd0, pready}, 32'h1);
    rd(4'd4, v);  chk("R1 enable", v, 32'h0);
    rd(4'd6, v);  chk("R1 trigger", v, 32'h0);
    rd(4'd8, v);  chk("R1 polarity", v, 32'h0);
    rd(4'd10, v); chk("R1 anyedge", v, 32'h0);
    rd(4'd13, v); chk("R1 mode", v, 32'h0);

    // R2 output set/clear
    wr(4'd0, 32'hF0); chk("R2 set", pin_out, 32'hF0);
    wr(4'd1, 32'h30); chk("R2 clear", pin_out, 32'hC0);
    wr(4'd0, 32'h01); chk("R2 zeros keep", pin_out, 32'hC1);
    // R3 direction
    wr(4'd2, 32'hFF); chk("R3 oe set", pin_oe, 32'hFF);
    wr(4'd3, 32'h0F); chk("R3 oe clear", pin_oe, 32'hF0);

    // R4 synchronized read
    @(negedge pclk); pin_in = 32'h0012_3400;
    wait_n(3);
    rd(4'd0, v); chk("R4 input read", v, 32'h0012_3400);
    @(negedge pclk); pin_in = '0; wait_n(3);

    // R6 R9 active-low default, status visible without enable
    rd(4'd1, v); chk("R9 status all level low", v, 32'hFFFFFFFF);
    wr(4'd4, 32'h2); chk("R6 active-low irq", {31'd0, irq}, 32'h1);
    wr(4'd5, 32'h2); chk("R9 disabled irq", {31'd0, irq}, 32'h0);

    // R6 R4 active-high level on pin0
    wr(4'd8, 32'h1); wr(4'd4, 32'h1);
    chk("R6 high idle", {31'd0, irq}, 32'h0);
    @(negedge pclk); pin_in[0] = 1'b1;
    @(negedge pclk); chk("R4 one edge early", {31'd0, irq}, 32'h0);
    @(negedge pclk); chk("R4 second edge", {31'd0, irq}, 32'h1);
    wr(4'd12, 32'h1); chk("R6 ack ignored", {31'd0, irq}, 32'h1);
    @(negedge pclk); pin_in[0] = 1'b0; wait_n(2);
    chk("R6 follows input", {31'd0, irq}, 32'h0);
    wr(4'd5, 32'h1);

    // R7 rising edge on pin2
    wr(4'd6, 32'h4); wr(4'd8, 32'h4); wr(4'd4, 32'h4);
    chk("R7 idle", {31'd0, irq}, 32'h0);
    @(negedge pclk); pin_in[2] = 1'b1;
    wait_n(2); chk("R7 before latch", {31'd0, irq}, 32'h0);
    wait_n(1); chk("R7 third edge", {31'd0, irq}, 32'h1);
    @(negedge pclk); pin_in[2] = 1'b0; wait_n(3);
    chk("R7 held", {31'd0, irq}, 32'h1);
    wr(4'd12, 32'h4); chk("R7 ack", {31'd0, irq}, 32'h0);
    wr(4'd5, 32'h4);

    // R7 falling edge on pin3
    wr(4'd6, 32'h8); wr(4'd4, 32'h8);
    @(negedge pclk); pin_in[3] = 1'b1; wait_n(4);
    chk("R7 wrong edge", {31'd0, irq}, 32'h0);
    @(negedge pclk); pin_in[3] = 1'b0; wait_n(3);
    chk("R7 falling", {31'd0, irq}, 32'h1);
    wr(4'd12, 32'h8); chk("R7 ack fall", {31'd0, irq}, 32'h0);
    wr(4'd5, 32'h8);

    // R8 any-edge on pin4
    wr(4'd6, 32'h10); wr(4'd8, 32'h10); wr(4'd10, 32'h10); wr(4'd4, 32'h10);
    @(negedge pclk); pin_in[4] = 1'b1; wait_n(3);
    chk("R8 any rise", {31'd0, irq}, 32'h1);
    wr(4'd12, 32'h10);
    @(negedge pclk); pin_in[4] = 1'b0; wait_n(3);
    chk("R8 any fall", {31'd0, irq}, 32'h1);
    wr(4'd12, 32'h10);
    wr(4'd11, 32'h10);
    @(negedge pclk); pin_in[4] = 1'b1; wait_n(3);
    chk("R8 cleared rise", {31'd0, irq}, 32'h1);
    wr(4'd12, 32'h10);
    @(negedge pclk); pin_in[4] = 1'b0; wait_n(4);
    chk("R8 cleared fall", {31'd0, irq}, 32'h0);
    wr(4'd5, 32'h10);

    // R9 status of a disabled edge pin
    wr(4'd6, 32'h20); wr(4'd8, 32'h20);
    @(negedge pclk); pin_in[5] = 1'b1; wait_n(3);
    chk("R9 irq masked", {31'd0, irq}, 32'h0);
    rd(4'd1, v); chk("R9 status visible", v & 32'h20, 32'h20);
    wr(4'd12, 32'h20);
    rd(4'd1, v); chk("R9 status acked", v & 32'h20, 32'h0);

    // R10 loopback
    wr(4'd13, 32'h1);
    @(negedge pclk); pin_in = 32'h0000FF00; wait_n(3);
    rd(4'd0, v); chk("R10 loopback", v, 32'hC1);
    wr(4'd13, 32'h0); wait_n(3);
    rd(4'd0, v); chk("R10 normal", v, 32'h0000FF00);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule